// File: doc/BRIEF.md
# SPI Flash Boot Reader

This block is the SPI master that fetches a boot image from a serial flash after reset. On a start pulse it pulls the active-low slave select down and sends a 32-bit read header on MOSI. The header is the read opcode 0x03 followed by a 24-bit start address of zero. The block then keeps SCLK running and gathers MISO into bytes, presenting each finished byte for one cycle on a strobed output. A downstream CRC checker or loader can consume that byte stream directly.

The serial clock is the reference clock divided by a fixed ratio, 40 by default. With a 100 MHz reference this gives 2.5 MHz. The bus works in mode 0: SCLK idles low, both sides sample on the rising edge, and data moves on the falling edge. Incoming bytes are built least-significant bit first. A read ends when the number of bytes given at start has been delivered or when the abort input is raised. In both cases SCLK is parked low and slave select is released after a hold interval.

Top module: `spi_boot_reader`

## Requirements
- R1: After reset, ss_no is 1, sclk_o is 0, busy_o is 0 and byte_valid_o is 0.
- R2: A start_i pulse while idle drives ss_no low on the next clock edge. The first rising SCLK edge comes no earlier than CLK_DIV/2 reference cycles after that.
- R3: While clocking, SCLK has a period of exactly CLK_DIV reference cycles, and each high phase lasts CLK_DIV/2 cycles. SCLK stays low whenever ss_no is high. mosi_o does not change while SCLK is high.
- R4: The first 32 bits on MOSI, as seen at the first 32 rising SCLK edges, are 0x03000000 sent MSB first: the read opcode 0x03, then address 0x000000.
- R5: From the 33rd rising SCLK edge on, MISO is sampled on each rising edge. The first data bit sampled in each group of 8 becomes byte_o[0] and the last becomes byte_o[7].
- R6: byte_valid_o pulses for exactly one reference cycle when the 8th bit of a byte has been sampled, and byte_o holds that byte in the same cycle.
- R7: A read delivers exactly byte_count_i bytes, with the count taken at start, so it has 32 + 8·byte_count_i rising SCLK edges. ss_no rises CLK_DIV/2 cycles after the last falling SCLK edge. A count of 0 sends only the header.
- R8: abort_i raised during clocking makes SCLK low from the next cycle on, stops any further byte_valid_o, and releases ss_no within CLK_DIV/2 + 1 cycles.
- R9: busy_o is high exactly while ss_no is low.
- R10: start_i has no effect while busy_o is high. The running read keeps its header, its byte count and its edge count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a read (ignored while busy) |
| abort_i | input | 1 | Stop the read in progress |
| byte_count_i | input | CNT_W | Number of data bytes to fetch, taken at start |
| miso_i | input | 1 | Serial data from flash |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to flash |
| ss_no | output | 1 | Active-low slave select |
| busy_o | output | 1 | Read in progress |
| byte_o | output | 8 | Last assembled data byte |
| byte_valid_o | output | 1 | One-cycle strobe for byte_o |

## Verification
The hardest case to reach from the ports is an abort that arrives in the middle of the data phase. It must cut off clocking without letting a half-built byte escape as a valid strobe. The bench acts as the flash: it answers each falling SCLK edge with the next bit of a random image. It waits until a chosen number of bytes has been delivered and then pulses abort. After that it checks how fast SCLK is parked, how fast slave select is released, and that the byte count no longer moves. A second start pulse is also injected in the middle of a read, to show that the edge count and the header are unchanged.

// File: rtl/spi_boot_pkg.sv
package spi_boot_pkg;
  typedef enum logic [1:0] {
    RD_IDLE = 2'd0,
    RD_XFER = 2'd1,
    RD_HOLD = 2'd2
  } rd_state_e;

  localparam int HDR_BITS = 32;
  localparam logic [7:0] RD_OPCODE = 8'h03;
endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int HALF = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic count_en_i,
  input  logic toggle_en_i,
  input  logic halt_i,
  output logic tick_o,
  output logic rise_o,
  output logic fall_o,
  output logic sclk_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;

  assign tick_o = count_en_i && (cnt_q == CW'(HALF - 1));
  assign rise_o = tick_o && toggle_en_i && !halt_i && !sclk_q;
  assign fall_o = tick_o && toggle_en_i && !halt_i && sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      if (halt_i || !count_en_i || tick_o) cnt_q <= '0;
      else                                 cnt_q <= cnt_q + 1'b1;
      if (halt_i || !toggle_en_i) sclk_q <= 1'b0;
      else if (tick_o)            sclk_q <= ~sclk_q;
    end
  end

  // R3
  sclk_high_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_q) && !halt_i |=> sclk_q);
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  output logic         mosi_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= load_val_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign mosi_o = sh_q[W-1];
endmodule

// File: rtl/spi_rx_byte.sv
module spi_rx_byte (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       sample_i,
  input  logic       miso_i,
  output logic [7:0] byte_o,
  output logic       valid_o
);
  logic [7:0] sh_q;
  logic [2:0] bit_q;
  logic [7:0] byte_q;
  logic       valid_q;
  logic [7:0] next_sh;

  // LSB-first: new bits enter at the top and move down
  assign next_sh = {miso_i, sh_q[7:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (clr_i) begin
        bit_q <= '0;
      end else if (sample_i) begin
        sh_q  <= next_sh;
        bit_q <= bit_q + 1'b1;
        if (bit_q == 3'd7) begin
          byte_q  <= next_sh;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign byte_o  = byte_q;
  assign valid_o = valid_q;

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
endmodule

// File: rtl/spi_boot_reader.sv
module spi_boot_reader
  import spi_boot_pkg::*;
#(
  parameter int CLK_DIV = 40,
  parameter int CNT_W   = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             abort_i,
  input  logic [CNT_W-1:0] byte_count_i,
  input  logic             miso_i,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             ss_no,
  output logic             busy_o,
  output logic [7:0]       byte_o,
  output logic             byte_valid_o
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int HCW   = $clog2(HDR_BITS);
  localparam logic [HDR_BITS-1:0] HDR_WORD = {RD_OPCODE, 24'h000000};

  rd_state_e        state_q;
  logic             ss_q;
  logic             hdr_q;
  logic [HCW-1:0]   hdr_cnt_q;
  logic [2:0]       dbit_q;
  logic [CNT_W-1:0] done_q;
  logic [CNT_W-1:0] goal_q;

  logic accept, halt, tick, rise, fall;

  assign accept = (state_q == RD_IDLE) && start_i;
  assign halt   = (state_q == RD_XFER) && abort_i;

  spi_sclk_gen #(.HALF(HALF)) u_clk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .count_en_i  (state_q != RD_IDLE),
    .toggle_en_i (state_q == RD_XFER),
    .halt_i      (halt),
    .tick_o      (tick),
    .rise_o      (rise),
    .fall_o      (fall),
    .sclk_o      (sclk_o)
  );

  spi_tx_shift #(.W(HDR_BITS)) u_tx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept),
    .load_val_i (HDR_WORD),
    .shift_i    (fall),
    .mosi_o     (mosi_o)
  );

  spi_rx_byte u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (accept),
    .sample_i (rise && !hdr_q),
    .miso_i   (miso_i),
    .byte_o   (byte_o),
    .valid_o  (byte_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= RD_IDLE;
      ss_q      <= 1'b1;
      hdr_q     <= 1'b1;
      hdr_cnt_q <= '0;
      dbit_q    <= '0;
      done_q    <= '0;
      goal_q    <= '0;
    end else begin
      unique case (state_q)
        RD_IDLE: if (start_i) begin
          state_q   <= RD_XFER;
          ss_q      <= 1'b0;
          hdr_q     <= 1'b1;
          hdr_cnt_q <= '0;
          dbit_q    <= '0;
          done_q    <= '0;
          goal_q    <= byte_count_i;
        end
        RD_XFER: begin
          if (abort_i) begin
            state_q <= RD_HOLD;
          end else if (fall) begin
            if (hdr_q) begin
              hdr_cnt_q <= hdr_cnt_q + 1'b1;
              if (hdr_cnt_q == HCW'(HDR_BITS - 1)) begin
                hdr_q <= 1'b0;
                if (goal_q == '0) state_q <= RD_HOLD;
              end
            end else begin
              dbit_q <= dbit_q + 1'b1;
              if (dbit_q == 3'd7) begin
                done_q <= done_q + CNT_W'(1);
                if (done_q + CNT_W'(1) == goal_q) state_q <= RD_HOLD;
              end
            end
          end
        end
        RD_HOLD: if (tick) begin
          state_q <= RD_IDLE;
          ss_q    <= 1'b1;
        end
        default: state_q <= RD_IDLE;
      endcase
    end
  end

  assign ss_no  = ss_q;
  assign busy_o = (state_q != RD_IDLE);

  // R9
  busy_select_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == !ss_no);
  // R3
  idle_sclk_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ss_no |-> !sclk_o);
  // R3
  mosi_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o && $past(sclk_o) |-> $stable(mosi_o));
  // R8
  abort_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt |=> !sclk_o && !byte_valid_o);
  // R7
  no_excess_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |-> done_q <= goal_q);
endmodule

// File: tb/tb_spi_boot_reader.sv
`timescale 1ns/1ps
module tb_spi_boot_reader;
  localparam int CLK_DIV = 40;
  localparam int HALF    = CLK_DIV / 2;
  localparam int TCK     = 20;
  localparam int CNT_W   = 16;

  logic clk = 1'b0;
  logic rst_ni, start_i, abort_i, miso_i;
  logic [CNT_W-1:0] byte_count_i;
  logic sclk_o, mosi_o, ss_no, busy_o, byte_valid_o;
  logic [7:0] byte_o;

  always #(TCK/2) clk = ~clk;

  spi_boot_reader #(.CLK_DIV(CLK_DIV), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
    .byte_count_i(byte_count_i), .miso_i(miso_i), .sclk_o(sclk_o),
    .mosi_o(mosi_o), .ss_no(ss_no), .busy_o(busy_o), .byte_o(byte_o),
    .byte_valid_o(byte_valid_o)
  );

  int checks = 0, fails = 0;
  logic [7:0] mem [0:63];
  logic [7:0] got [0:63];
  int got_n = 0, rise_cnt = 0, period_err = 0, duty_err = 0, busy_err = 0;
  logic [31:0] hdr_word;
  bit abort_seen = 0;
  time ss_fall_t, ss_rise_t, first_rise_t, last_rise_t, last_fall_t;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  // flash model
  always @(negedge ss_no) begin
    ss_fall_t = $time;
    rise_cnt  = 0;
  end
  always @(posedge ss_no) ss_rise_t = $time;
  always @(posedge sclk_o) if (ss_no === 1'b0) begin
    if (rise_cnt == 0) first_rise_t = $time;
    else if ($time - last_rise_t != CLK_DIV * TCK) period_err++;
    last_rise_t = $time;
    if (rise_cnt < 32) hdr_word = {hdr_word[30:0], mosi_o};
    rise_cnt++;
  end
  always @(negedge sclk_o) if (ss_no === 1'b0) begin
    if (!abort_seen && ($time - last_rise_t != HALF * TCK)) duty_err++;
    last_fall_t = $time;
    if (rise_cnt >= 32 && rise_cnt - 32 < 512)
      miso_i = mem[(rise_cnt - 32) / 8][(rise_cnt - 32) % 8];
  end

  always @(negedge clk) begin
    if (byte_valid_o === 1'b1 && got_n < 64) begin
      got[got_n] = byte_o;
      got_n++;
    end
    if (rst_ni === 1'b1 && busy_o !== !ss_no) busy_err++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
  end

  task automatic wait_release(input int limit);
    int n = 0;
    while (ss_no !== 1'b1 && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk(ss_no === 1'b1, "R7 release timeout", n, limit);
  endtask

  task automatic run_read(input int n, input bit glitch, input bit fixed);
    int bad = 0;
    for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
    if (fixed) begin
      mem[0] = 8'h01;
      mem[1] = 8'h80;
    end
    got_n = 0; period_err = 0; duty_err = 0; abort_seen = 0; hdr_word = '0;
    @(negedge clk);
    byte_count_i = CNT_W'(n);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(ss_no === 1'b0 && busy_o === 1'b1, "R2 select asserted", {ss_no, busy_o}, 2'b01);
    if (glitch) begin
      repeat (300) @(negedge clk);
      byte_count_i = CNT_W'(n + 5);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_release((32 + 8 * n + 4) * CLK_DIV);
    chk(hdr_word == 32'h03000000, "R4 header", hdr_word, 32'h03000000);
    chk(first_rise_t - ss_fall_t >= HALF * TCK, "R2 setup", first_rise_t - ss_fall_t, HALF * TCK);
    chk(period_err == 0 && duty_err == 0, "R3 sclk timing", period_err + duty_err, 0);
    chk(got_n == n, "R7 byte count", got_n, n);
    chk(rise_cnt == 32 + 8 * n, glitch ? "R10 edge count" : "R7 edge count", rise_cnt, 32 + 8 * n);
    chk(ss_rise_t - last_fall_t == HALF * TCK, "R7 hold", ss_rise_t - last_fall_t, HALF * TCK);
    for (int i = 0; i < n && i < got_n; i++) begin
      if (got[i] !== mem[i] && bad == 0) begin
        bad = 1;
        chk(0, "R5 R6 data", got[i], mem[i]);
      end
    end
    if (bad == 0) chk(1, "R5 R6 data", 0, 0);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1357));
    rst_ni = 1'b0; start_i = 1'b0; abort_i = 1'b0; miso_i = 1'b0; byte_count_i = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ss_no === 1'b1, "R1 ss_no", ss_no, 1);
    chk(sclk_o === 1'b0, "R1 sclk_o", sclk_o, 0);
    chk(busy_o === 1'b0, "R1 busy_o", busy_o, 0);
    chk(byte_valid_o === 1'b0, "R1 byte_valid_o", byte_valid_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);

    run_read(0, 0, 0);   // header only
    run_read(2, 0, 1);   // bit order: 0x01 and 0x80
    run_read(1, 0, 0);
    for (int k = 0; k < 4; k++) run_read(2 + int'($urandom % 11), 0, 0);
    run_read(6, 1, 0);   // R10 start while busy

    // R8 abort in data phase
    begin
      int cyc = 0;
      for (int i = 0; i < 64; i++) mem[i] = 8'($urandom);
      got_n = 0;
      @(negedge clk);
      byte_count_i = CNT_W'(20);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      while (got_n < 3 && cyc < 20000) begin
        @(negedge clk);
        cyc++;
      end
      abort_seen = 1;
      abort_i = 1'b1;
      @(negedge clk);
      abort_i = 1'b0;
      chk(sclk_o === 1'b0, "R8 sclk parked", sclk_o, 0);
      cyc = 1;
      while (ss_no !== 1'b1 && cyc < 200) begin
        @(negedge clk);
        cyc++;
      end
      chk(cyc <= HALF + 1, "R8 release delay", cyc, HALF + 1);
      repeat (4 * CLK_DIV) @(negedge clk);
      chk(got_n == 3, "R8 bytes after abort", got_n, 3);
      chk(got[0] === mem[0] && got[2] === mem[2], "R8 data kept", got[2], mem[2]);
      chk(sclk_o === 1'b0 && busy_o === 1'b0, "R8 idle after abort", {sclk_o, busy_o}, 0);
    end

    run_read(3, 0, 0);   // clean read after abort
    chk(busy_err == 0, "R9 busy vs select", busy_err, 0);
    summary();
  end
endmodule